// File: doc/BRIEF.md
# Duplicate-State Directory Cache

This block holds the directory state of one node in two forms. A compact array keeps two bits per cache line and answers snoop lookups from a pipelined system bus. A small direct-mapped cache keeps full directory entries for the protocol engine. Each full entry is a presence bit per node plus an owner flag. The cache is write-through, so the backing store is always current. A line that is not present is fetched from the backing store over a simple request and return-data interface.

Every engine write updates three things at once: the cached entry, the compact bus-side state of that line, and the backing store. The compact state is computed from the written entry, so the bus view never drifts from the full view. A read that hits answers in one cycle. A read that misses stalls the engine port until the backing store returns the entry. That takes several times longer than a hit.

Top module: `dir_dup_cache`

## Requirements
- R1: After reset, every bus-side line reads as uncached (2'b00) and no cache entry is valid. The first engine read of any line therefore goes to the backing store.
- R2: The bus side accepts a lookup only when `bus_rdy` is high. `bus_rdy` is low for exactly the cycle after an accepted lookup, so a request held in that cycle is refused.
- R3: An accepted lookup raises `bus_rsp_vld` for one cycle, in the cycle after acceptance, together with the 2-bit state of the addressed line.
- R4: The bus-side code is computed from the full entry. Bit NODES of the entry is the owner flag and bits NODES-1:0 are the presence map. The code is 2'b10 (dirty-remote) when the owner flag is set, 2'b01 (shared) when the owner flag is clear and any presence bit is set, and 2'b00 (uncached) otherwise. 2'b11 is reserved and is never reported.
- R5: An engine write is accepted in one cycle. It raises `eng_done` in the next cycle and updates both the cached entry and the bus-side state of that line.
- R6: Every accepted engine write drives `mem_req` and `mem_we` high for one cycle in the cycle after acceptance, with the written address and entry.
- R7: An engine read that hits raises `eng_done` in the next cycle with the cached entry on `eng_rdata`, and makes no backing-store request.
- R8: An engine read that misses issues a backing-store read (`mem_req` high, `mem_we` low) in the next cycle. `eng_rdy` stays low until `mem_rvalid`. In the cycle after `mem_rvalid`, `eng_done` rises with the returned entry, the line is filled, and a repeated read of that line hits.
- R9: The cache is direct-mapped. The low SET_AW bits of the line address are the index and the remaining bits are the tag. A write or fill to one line evicts any other line that has the same index.
- R10: A lookup accepted in the same cycle as an engine write to the same line returns the state held before the write. A lookup accepted in any later cycle returns the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus-side lookup request |
| bus_addr | input | LINE_AW | Line address of the lookup |
| bus_rdy | output | 1 | Lookup can be accepted this cycle |
| bus_rsp_vld | output | 1 | Lookup result valid |
| bus_state | output | 2 | Compact state of the looked-up line |
| eng_req | input | 1 | Engine request |
| eng_we | input | 1 | Engine request is a write |
| eng_addr | input | LINE_AW | Engine line address |
| eng_wdata | input | NODES+1 | Full entry to write (owner flag in the top bit) |
| eng_rdy | output | 1 | Engine request can be accepted this cycle |
| eng_done | output | 1 | Engine request completed |
| eng_rdata | output | NODES+1 | Entry returned by a read |
| mem_req | output | 1 | Backing-store request |
| mem_we | output | 1 | Backing-store request is a write |
| mem_addr | output | LINE_AW | Backing-store line address |
| mem_wdata | output | NODES+1 | Entry written to the backing store |
| mem_rvalid | input | 1 | Backing-store read data valid |
| mem_rdata | input | NODES+1 | Backing-store read data |

## Verification
Several properties are checked by assertions on every cycle. No lookup is accepted in two consecutive cycles, and no reserved code is ever written or reported. Each accepted write produces a matching backing-store write in the next cycle. Each hit completes without touching the backing store, and a fill returns exactly the data delivered by the backing store. Other properties depend on stored history, and only the bench's scenarios can show them: that the bus-side code matches the last entry written to a line, that conflicting lines evict each other, and that a lookup colliding with a write sees the prior state. The bench shows these with a behavioural model compared on every clock, backed by directed sequences.

// File: rtl/dir_dup_pkg.sv
package dir_dup_pkg;

    // Compact bus-side line state codes
    localparam logic [1:0] BST_NONE = 2'b00;   // no node holds the line
    localparam logic [1:0] BST_SHRD = 2'b01;   // one or more read-only holders
    localparam logic [1:0] BST_DREM = 2'b10;   // a remote node owns a dirty copy
    localparam logic [1:0] BST_RSVD = 2'b11;   // never produced

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_FILL = 1'b1
    } eng_mode_e;

    // Derive the compact code from the owner flag and the OR of the presence map
    function automatic logic [1:0] bst_of(input logic owner, input logic any_present);
        if (owner) begin
            return BST_DREM;
        end else if (any_present) begin
            return BST_SHRD;
        end
        return BST_NONE;
    endfunction

endpackage

// File: rtl/dir_bus_state.sv
module dir_bus_state
    import dir_dup_pkg::*;
#(
    parameter int LINE_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINE_AW-1:0] rd_addr,
    output logic [1:0]         rd_state,
    input  logic               wr_en,
    input  logic [LINE_AW-1:0] wr_addr,
    input  logic [1:0]         wr_state
);

    localparam int LINES = 1 << LINE_AW;

    logic [1:0] st_q [LINES];

    assign rd_state = st_q[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i] <= BST_NONE;
            end
        end else if (wr_en) begin
            st_q[wr_addr] <= wr_state;
        end
    end

    // R4: the reserved code never enters the compact array
    assert_wr_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_state != BST_RSVD));

endmodule

// File: rtl/dir_entry_cache.sv
module dir_entry_cache #(
    parameter int SET_AW = 4,
    parameter int TAG_W  = 6,
    parameter int ENT_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_AW-1:0] rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ENT_W-1:0]  rd_data,
    input  logic              wr_en,
    input  logic [SET_AW-1:0] wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ENT_W-1:0]  wr_data
);

    localparam int SETS = 1 << SET_AW;

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [ENT_W-1:0] dat_q [SETS];

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = dat_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            dat_q[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/dir_bus_port.sv
module dir_bus_port
    import dir_dup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req,
    input  logic [1:0] rd_state,
    output logic       bus_rdy,
    output logic       bus_rsp_vld,
    output logic [1:0] bus_state
);

    typedef struct packed {
        logic       busy;
        logic       vld;
        logic [1:0] st;
    } bp_s;

    bp_s  q, d;
    logic acc;

    assign bus_rdy     = !q.busy;
    assign acc         = bus_req && !q.busy;
    assign bus_rsp_vld = q.vld;
    assign bus_state   = q.st;

    always_comb begin
        d      = q;
        d.busy = acc;
        d.vld  = acc;
        if (acc) begin
            d.st = rd_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: accepted lookups are at least two cycles apart
    assert_bus_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_rdy) |=> !(bus_req && bus_rdy));

    // R3: a response follows every accepted lookup
    assert_bus_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_rdy) |=> bus_rsp_vld);

endmodule

// File: rtl/dir_eng_ctrl.sv
module dir_eng_ctrl
    import dir_dup_pkg::*;
#(
    parameter int LINE_AW = 10,
    parameter int SET_AW  = 4,
    parameter int NODES   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        eng_req,
    input  logic                        eng_we,
    input  logic [LINE_AW-1:0]          eng_addr,
    input  logic [NODES:0]              eng_wdata,
    output logic                        eng_rdy,
    output logic                        eng_done,
    output logic [NODES:0]              eng_rdata,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [LINE_AW-1:0]          mem_addr,
    output logic [NODES:0]              mem_wdata,
    input  logic                        mem_rvalid,
    input  logic [NODES:0]              mem_rdata,
    output logic [SET_AW-1:0]           c_rd_idx,
    input  logic                        c_rd_valid,
    input  logic [LINE_AW-SET_AW-1:0]   c_rd_tag,
    input  logic [NODES:0]              c_rd_data,
    output logic                        c_wr_en,
    output logic [SET_AW-1:0]           c_wr_idx,
    output logic [LINE_AW-SET_AW-1:0]   c_wr_tag,
    output logic [NODES:0]              c_wr_data,
    output logic                        b_wr_en,
    output logic [LINE_AW-1:0]          b_wr_addr,
    output logic [1:0]                  b_wr_state
);

    localparam int ENT_W = NODES + 1;
    localparam int TAG_W = LINE_AW - SET_AW;

    typedef struct packed {
        eng_mode_e          mode;
        logic               done;
        logic [ENT_W-1:0]   rdata;
        logic               mreq;
        logic               mwe;
        logic [LINE_AW-1:0] maddr;
        logic [ENT_W-1:0]   mwdata;
    } ec_s;

    ec_s  q, d;
    logic hit;
    logic accept;

    assign eng_rdy   = (q.mode == ENG_IDLE);
    assign accept    = eng_req && eng_rdy;
    assign eng_done  = q.done;
    assign eng_rdata = q.rdata;
    assign mem_req   = q.mreq;
    assign mem_we    = q.mwe;
    assign mem_addr  = q.maddr;
    assign mem_wdata = q.mwdata;

    assign c_rd_idx = eng_addr[SET_AW-1:0];
    assign hit      = c_rd_valid && (c_rd_tag == eng_addr[LINE_AW-1:SET_AW]);

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.mreq     = 1'b0;
        c_wr_en    = 1'b0;
        c_wr_idx   = eng_addr[SET_AW-1:0];
        c_wr_tag   = eng_addr[LINE_AW-1:SET_AW];
        c_wr_data  = eng_wdata;
        b_wr_en    = 1'b0;
        b_wr_addr  = eng_addr;
        b_wr_state = bst_of(eng_wdata[NODES], |eng_wdata[NODES-1:0]);
        unique case (q.mode)
            ENG_IDLE: begin
                if (eng_req) begin
                    if (eng_we) begin
                        c_wr_en  = 1'b1;
                        b_wr_en  = 1'b1;
                        d.mreq   = 1'b1;
                        d.mwe    = 1'b1;
                        d.maddr  = eng_addr;
                        d.mwdata = eng_wdata;
                        d.done   = 1'b1;
                    end else if (hit) begin
                        d.done  = 1'b1;
                        d.rdata = c_rd_data;
                    end else begin
                        d.mreq  = 1'b1;
                        d.mwe   = 1'b0;
                        d.maddr = eng_addr;
                        d.mode  = ENG_FILL;
                    end
                end
            end
            ENG_FILL: begin
                if (mem_rvalid) begin
                    c_wr_en   = 1'b1;
                    c_wr_idx  = q.maddr[SET_AW-1:0];
                    c_wr_tag  = q.maddr[LINE_AW-1:SET_AW];
                    c_wr_data = mem_rdata;
                    d.done    = 1'b1;
                    d.rdata   = mem_rdata;
                    d.mode    = ENG_IDLE;
                end
            end
            default: d.mode = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R6: every accepted write reaches the backing store next cycle
    assert_write_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && eng_we) |=> (mem_req && mem_we && mem_addr == $past(eng_addr)
                                && mem_wdata == $past(eng_wdata)));

    // R7: a hit completes next cycle without a backing-store access
    assert_hit_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !eng_we && hit) |=> (eng_done && !mem_req));

    // R8: the fill returns exactly what the backing store delivered
    assert_fill_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_rdy && mem_rvalid) |=> (eng_done && eng_rdy && eng_rdata == $past(mem_rdata)));

    // R8: a miss issues a backing-store read and blocks the port
    assert_miss_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !eng_we && !hit) |=> (mem_req && !mem_we && !eng_rdy));

endmodule

// File: rtl/dir_dup_cache.sv
module dir_dup_cache
    import dir_dup_pkg::*;
#(
    parameter int NODES   = 16,
    parameter int LINE_AW = 10,
    parameter int SET_AW  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic [LINE_AW-1:0] bus_addr,
    output logic               bus_rdy,
    output logic               bus_rsp_vld,
    output logic [1:0]         bus_state,
    input  logic               eng_req,
    input  logic               eng_we,
    input  logic [LINE_AW-1:0] eng_addr,
    input  logic [NODES:0]     eng_wdata,
    output logic               eng_rdy,
    output logic               eng_done,
    output logic [NODES:0]     eng_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [LINE_AW-1:0] mem_addr,
    output logic [NODES:0]     mem_wdata,
    input  logic               mem_rvalid,
    input  logic [NODES:0]     mem_rdata
);

    localparam int ENT_W = NODES + 1;
    localparam int TAG_W = LINE_AW - SET_AW;

    logic [1:0]         rd_state;
    logic [SET_AW-1:0]  c_rd_idx;
    logic               c_rd_valid;
    logic [TAG_W-1:0]   c_rd_tag;
    logic [ENT_W-1:0]   c_rd_data;
    logic               c_wr_en;
    logic [SET_AW-1:0]  c_wr_idx;
    logic [TAG_W-1:0]   c_wr_tag;
    logic [ENT_W-1:0]   c_wr_data;
    logic               b_wr_en;
    logic [LINE_AW-1:0] b_wr_addr;
    logic [1:0]         b_wr_state;

    dir_bus_state #(.LINE_AW(LINE_AW)) u_bst (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (bus_addr),
        .rd_state (rd_state),
        .wr_en    (b_wr_en),
        .wr_addr  (b_wr_addr),
        .wr_state (b_wr_state)
    );

    dir_bus_port u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .rd_state    (rd_state),
        .bus_rdy     (bus_rdy),
        .bus_rsp_vld (bus_rsp_vld),
        .bus_state   (bus_state)
    );

    dir_entry_cache #(.SET_AW(SET_AW), .TAG_W(TAG_W), .ENT_W(ENT_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (c_rd_idx),
        .rd_valid (c_rd_valid),
        .rd_tag   (c_rd_tag),
        .rd_data  (c_rd_data),
        .wr_en    (c_wr_en),
        .wr_idx   (c_wr_idx),
        .wr_tag   (c_wr_tag),
        .wr_data  (c_wr_data)
    );

    dir_eng_ctrl #(.LINE_AW(LINE_AW), .SET_AW(SET_AW), .NODES(NODES)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_req    (eng_req),
        .eng_we     (eng_we),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .eng_rdy    (eng_rdy),
        .eng_done   (eng_done),
        .eng_rdata  (eng_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .c_rd_idx   (c_rd_idx),
        .c_rd_valid (c_rd_valid),
        .c_rd_tag   (c_rd_tag),
        .c_rd_data  (c_rd_data),
        .c_wr_en    (c_wr_en),
        .c_wr_idx   (c_wr_idx),
        .c_wr_tag   (c_wr_tag),
        .c_wr_data  (c_wr_data),
        .b_wr_en    (b_wr_en),
        .b_wr_addr  (b_wr_addr),
        .b_wr_state (b_wr_state)
    );

    // R4: the reserved code is never reported on the bus side
    assert_no_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rsp_vld |-> (bus_state != BST_RSVD));

endmodule

// File: tb/sim_dir_dup_cache.sv
module sim_dir_dup_cache;

    localparam int NODES   = 16;
    localparam int LINE_AW = 10;
    localparam int SET_AW  = 4;
    localparam int ENT_W   = NODES + 1;
    localparam int LINES   = 1 << LINE_AW;
    localparam int SETS    = 1 << SET_AW;
    localparam int MEM_LAT = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_req = 1'b0;
    logic [LINE_AW-1:0] bus_addr = '0;
    logic               bus_rdy, bus_rsp_vld;
    logic [1:0]         bus_state;
    logic               eng_req = 1'b0, eng_we = 1'b0;
    logic [LINE_AW-1:0] eng_addr = '0;
    logic [ENT_W-1:0]   eng_wdata = '0;
    logic               eng_rdy, eng_done;
    logic [ENT_W-1:0]   eng_rdata;
    logic               mem_req, mem_we;
    logic [LINE_AW-1:0] mem_addr;
    logic [ENT_W-1:0]   mem_wdata;
    logic               mem_rvalid = 1'b0;
    logic [ENT_W-1:0]   mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dir_dup_cache #(.NODES(NODES), .LINE_AW(LINE_AW), .SET_AW(SET_AW)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Backing store: posted writes, reads answered after MEM_LAT cycles
    logic [ENT_W-1:0] marr [LINES];
    int               m_cnt = 0;
    logic [LINE_AW-1:0] m_raddr = '0;
    initial for (int i = 0; i < LINES; i++) marr[i] = '0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && mem_we) begin
            marr[mem_addr] = mem_wdata;
        end else if (mem_req) begin
            m_cnt   = MEM_LAT;
            m_raddr = mem_addr;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= marr[m_raddr];
            end
        end
    end

    // Behavioural reference model
    function automatic logic [1:0] enc(input logic [ENT_W-1:0] e);
        if (e[NODES]) return 2'b10;
        if (e[NODES-1:0] != 0) return 2'b01;
        return 2'b00;
    endfunction

    logic [1:0]       r_bst [LINES];
    bit               r_val [SETS];
    int               r_tag [SETS];
    logic [ENT_W-1:0] r_dat [SETS];
    bit  x_bus_rdy, x_bvld, x_eng_rdy, x_done, x_rd, x_mreq, x_mwe, pend;
    logic [1:0]         x_bst;
    logic [ENT_W-1:0]   x_rdata, x_mwd;
    logic [LINE_AW-1:0] x_maddr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) r_bst[i] = 2'b00;
            for (int i = 0; i < SETS; i++) r_val[i] = 1'b0;
            x_bus_rdy = 1; x_bvld = 0; x_eng_rdy = 1; x_done = 0; x_rd = 0;
            x_mreq = 0; x_mwe = 0; pend = 0; x_bst = 0; x_rdata = 0; x_mwd = 0; x_maddr = 0;
        end else begin
            if (bus_req && x_bus_rdy) begin
                x_bvld = 1; x_bst = r_bst[bus_addr]; x_bus_rdy = 0;
            end else begin
                x_bvld = 0; x_bus_rdy = 1;
            end
            x_done = 0; x_rd = 0; x_mreq = 0;
            if (!pend) begin
                if (eng_req) begin
                    int ix, tg;
                    ix = int'(eng_addr) % SETS;
                    tg = int'(eng_addr) / SETS;
                    if (eng_we) begin
                        r_val[ix] = 1; r_tag[ix] = tg; r_dat[ix] = eng_wdata;
                        r_bst[eng_addr] = enc(eng_wdata);
                        x_mreq = 1; x_mwe = 1; x_maddr = eng_addr; x_mwd = eng_wdata;
                        x_done = 1;
                    end else if (r_val[ix] && r_tag[ix] == tg) begin
                        x_done = 1; x_rd = 1; x_rdata = r_dat[ix];
                    end else begin
                        x_mreq = 1; x_mwe = 0; x_maddr = eng_addr; pend = 1;
                    end
                end
            end else if (mem_rvalid) begin
                r_val[int'(x_maddr) % SETS] = 1;
                r_tag[int'(x_maddr) % SETS] = int'(x_maddr) / SETS;
                r_dat[int'(x_maddr) % SETS] = mem_rdata;
                x_done = 1; x_rd = 1; x_rdata = mem_rdata; pend = 0;
            end
            x_eng_rdy = !pend;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(bus_rdy == x_bus_rdy, "R2 bus_rdy", bus_rdy, x_bus_rdy);
            chk(bus_rsp_vld == x_bvld, "R3 bus_rsp_vld", bus_rsp_vld, x_bvld);
            if (x_bvld) chk(bus_state == x_bst, "R4 bus_state", bus_state, x_bst);
            chk(eng_rdy == x_eng_rdy, "R8 eng_rdy", eng_rdy, x_eng_rdy);
            chk(eng_done == x_done, "R5 eng_done", eng_done, x_done);
            if (x_rd) chk(eng_rdata == x_rdata, "R7 eng_rdata", eng_rdata, x_rdata);
            chk(mem_req == x_mreq, "R6 mem_req", mem_req, x_mreq);
            if (x_mreq) begin
                chk(mem_we == x_mwe, "R6 mem_we", mem_we, x_mwe);
                chk(mem_addr == x_maddr, "R6 mem_addr", mem_addr, x_maddr);
                if (x_mwe) chk(mem_wdata == x_mwd, "R6 mem_wdata", mem_wdata, x_mwd);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic eng_set(input bit rq, input bit we, input int a, input logic [ENT_W-1:0] wd);
        eng_req = rq; eng_we = we; eng_addr = LINE_AW'(a); eng_wdata = wd;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!eng_done && n < 100) begin
            tick();
            n++;
        end
    endtask

    int lat;

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: every line uncached after reset
        bus_req = 1; bus_addr = 5;
        tick();
        chk(bus_rsp_vld && bus_state == 2'b00, "R1 reset state", bus_state, 0);
        chk(!bus_rdy, "R2 busy after accept", bus_rdy, 0);
        bus_addr = 6;
        tick();
        chk(!bus_rsp_vld, "R2 second request refused", bus_rsp_vld, 0);
        tick();
        chk(bus_rsp_vld && bus_state == 2'b00, "R3 retry answered", bus_rsp_vld, 1);
        bus_req = 0;

        // R1: first read misses
        eng_set(1, 0, 3, '0);
        tick();
        eng_set(0, 0, 0, '0);
        chk(!eng_rdy && mem_req && !mem_we, "R1 first read misses", eng_rdy, 0);
        wait_done(lat);
        chk(eng_rdata == 0, "R8 miss data", eng_rdata, 0);
        chk(lat >= 5, "R8 miss slower than hit", lat, 5);

        // R5/R6: writes
        eng_set(1, 1, 3, 17'h00005);
        tick();
        chk(eng_done && mem_req && mem_we && mem_addr == 3 && mem_wdata == 17'h00005,
            "R6 write-through", mem_wdata, 17'h00005);
        eng_set(1, 1, 19, 17'h10002);
        tick();
        eng_set(1, 1, 7, 17'h00000);
        tick();
        eng_set(0, 0, 0, '0);

        // R4: bus codes follow written entries
        bus_req = 1; bus_addr = 3;
        tick();
        chk(bus_state == 2'b01, "R4 shared", bus_state, 2'b01);
        bus_req = 0;
        tick();
        bus_req = 1; bus_addr = 19;
        tick();
        chk(bus_state == 2'b10, "R4 dirty-remote", bus_state, 2'b10);
        bus_req = 0;
        tick();
        bus_req = 1; bus_addr = 7;
        tick();
        chk(bus_state == 2'b00, "R4 uncached", bus_state, 2'b00);
        bus_req = 0;

        // R7: hit on line 19
        eng_set(1, 0, 19, '0);
        tick();
        eng_set(0, 0, 0, '0);
        chk(eng_done && eng_rdata == 17'h10002 && !mem_req, "R7 hit", eng_rdata, 17'h10002);

        // R9: line 3 was evicted by line 19
        eng_set(1, 0, 3, '0);
        tick();
        eng_set(0, 0, 0, '0);
        chk(!eng_done && mem_req, "R9 evicted line misses", mem_req, 1);
        wait_done(lat);
        chk(eng_rdata == 17'h00005, "R9 refetched entry", eng_rdata, 17'h00005);
        eng_set(1, 0, 3, '0);
        tick();
        eng_set(0, 0, 0, '0);
        chk(eng_done && eng_rdata == 17'h00005, "R8 filled line hits", eng_rdata, 17'h00005);
        eng_set(1, 0, 19, '0);
        tick();
        eng_set(0, 0, 0, '0);
        chk(mem_req && !mem_we, "R9 fill evicted the other line", mem_req, 1);
        wait_done(lat);
        chk(eng_rdata == 17'h10002, "R9 entry kept in backing store", eng_rdata, 17'h10002);

        // R10: lookup colliding with a write
        bus_req = 1; bus_addr = 40;
        eng_set(1, 1, 40, 17'h10001);
        tick();
        eng_set(0, 0, 0, '0);
        chk(bus_rsp_vld && bus_state == 2'b00, "R10 same-cycle sees prior", bus_state, 2'b00);
        tick();
        tick();
        chk(bus_rsp_vld && bus_state == 2'b10, "R10 later sees new", bus_state, 2'b10);
        bus_req = 0;

        // Mixed traffic compared against the model every cycle
        for (int k = 0; k < 400; k++) begin
            bus_req  = $urandom_range(0, 1);
            bus_addr = LINE_AW'($urandom_range(0, 63));
            eng_set($urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 63), ENT_W'($urandom));
            tick();
        end
        bus_req = 0;
        eng_set(0, 0, 0, '0);
        repeat (20) tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule